// File: doc/BRIEF.md
# Dual-Mode Burst Serializer with Byte Inversion

This block takes one 256-bit write word and drives it onto a 16-lane data channel as a single 32-byte burst. Before the payload is serialized, each byte lane of every one-bit-per-lane beat is checked for its count of ones. A byte with too many ones is sent inverted, and a flag records that it was inverted. This limits how many lines switch to the high level at the same time.

The burst takes one of two shapes, chosen per word. In binary mode every lane carries one bit per beat, so the word takes 16 beats. In four-level mode every lane carries a 2-bit symbol per beat, so the same 32 bytes take 8 beats. Both modes use one inversion datapath, and inversion is always applied before symbols are packed. Words enter through a valid/ready handshake. A word offered during the last beat of a burst is taken at once, so the next burst follows with no idle beat between them.

Top module: `fmt_burst_dbi`

## Requirements
- R1: A word is accepted on the rising edge where `in_valid` and `in_ready` are both high. Its first beat appears in the next cycle with `out_valid` high, and `out_valid` stays high for every beat of the burst.
- R2: In binary mode (`in_mode`=0) the burst has 16 beats. In beat k, bit 0 of lane l's symbol field `out_sym[2l+1:2l]` is payload bit 16k+l after inversion, and bit 1 of that field is 0.
- R3: In four-level mode (`in_mode`=1) the burst has 8 beats. In beat k, lane l's field `out_sym[2l+1:2l]` is {lane l bit of binary beat 2k, lane l bit of binary beat 2k+1}. Both bits are taken after inversion, and the symbol takes any of the codes 00, 01, 10 and 11.
- R4: Inversion works per binary beat and per byte lane. Byte lane 0 is bits [7:0] of the 16-bit beat and byte lane 1 is bits [15:8]. A byte with more than four ones is sent complemented. A byte with four or fewer ones, exactly four included, is sent as is.
- R5: `out_dbi[2b+1:2b]` is the flag field of byte lane b. In binary mode it is {0, flag}. In four-level mode it is {flag of binary beat 2k, flag of binary beat 2k+1}. A flag is 1 exactly when that byte was inverted.
- R6: While a burst is being sent, `in_ready` is low on every beat except the last. On the last beat it is high.
- R7: A word accepted during the last beat has its first beat in the very next cycle, so back-to-back bursts have no gap.
- R8: The mode is sampled only when a word is accepted. Changes to `in_mode` or `in_data` during a burst do not affect that burst.
- R9: After reset, and whenever no burst is in progress, `out_valid` is 0, `in_ready` is 1, and `out_sym` and `out_dbi` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A write word is offered |
| in_ready | output | 1 | The block can take a word on this edge |
| in_data | input | 256 | Payload; binary beat k is bits [16k+15:16k] |
| in_mode | input | 1 | 0 = one bit per lane per beat, 1 = two-bit symbols |
| out_valid | output | 1 | A beat is present on the outputs |
| out_sym | output | 32 | Two-bit symbol field per lane, lane l at [2l+1:2l] |
| out_dbi | output | 4 | Two-bit inversion field per byte lane, lane b at [2b+1:2b] |

## Verification
The bench sends every byte value from 0 to 255 through both modes, so it hits the thresholds at exactly four and exactly five ones. An inverter that flips at four ones, or one that counts bits in the wrong byte lane, gives wrong symbols and wrong flags on those beats. In four-level mode the order of the two bits in a symbol and of the two flags in a field is checked on every beat; swapping either pair shows up as a wrong symbol or flag code. During every burst the bench holds a complemented word with the opposite mode on the inputs. A design that samples the mode or data mid-burst, or drops `in_ready` on the last beat, shows a changed beat length, corrupted data or a missing back-to-back start.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic {
        MODE_BIN  = 1'b0,
        MODE_QUAD = 1'b1
    } fmt_mode_e;

endpackage

// File: rtl/fmt_dbi_byte.sv
module fmt_dbi_byte #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         inv
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(din[i]);
        end
        inv  = (ones > CW'(W / 2));
        dout = inv ? ~din : din;
    end
endmodule

// File: rtl/fmt_beat_slice.sv
module fmt_beat_slice #(
    parameter int LANES     = 16,
    parameter int BYTE_W    = 8,
    parameter int BIN_BEATS = 16,
    localparam int PAY_W    = LANES * BIN_BEATS,
    localparam int NBYTES   = LANES / BYTE_W,
    localparam int CNT_W    = $clog2(BIN_BEATS)
) (
    input  logic [PAY_W-1:0]  pay,
    input  logic [CNT_W-1:0]  idx,
    output logic [LANES-1:0]  bits,
    output logic [NBYTES-1:0] flag
);
    logic [LANES-1:0] raw;

    assign raw = pay[int'(idx)*LANES +: LANES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        fmt_dbi_byte #(.W(BYTE_W)) u_inv (
            .din  (raw[b*BYTE_W +: BYTE_W]),
            .dout (bits[b*BYTE_W +: BYTE_W]),
            .inv  (flag[b])
        );
    end
endmodule

// File: rtl/fmt_burst_dbi.sv
module fmt_burst_dbi
    import fmt_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int BYTE_W    = 8,
    parameter int BIN_BEATS = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [LANES*BIN_BEATS-1:0]      in_data,
    input  logic                            in_mode,
    output logic                            out_valid,
    output logic [2*LANES-1:0]              out_sym,
    output logic [2*(LANES/BYTE_W)-1:0]     out_dbi
);
    localparam int PAY_W     = LANES * BIN_BEATS;
    localparam int NBYTES    = LANES / BYTE_W;
    localparam int SYM_BEATS = BIN_BEATS / 2;
    localparam int CNT_W     = $clog2(BIN_BEATS);

    typedef struct packed {
        logic             busy;
        fmt_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [PAY_W-1:0] pay;
    } state_t;

    state_t s_d, s_q;

    logic             quad_q;
    logic             at_last;
    logic [CNT_W-1:0] last_idx;
    logic [CNT_W-1:0] idx_a_d, idx_b_d;

    logic [LANES-1:0]  bits_a, bits_b;
    logic [NBYTES-1:0] flag_a, flag_b;

    assign quad_q = (s_q.mode == MODE_QUAD);

    // next-state and handshake
    always_comb begin
        last_idx = quad_q ? CNT_W'(SYM_BEATS - 1) : CNT_W'(BIN_BEATS - 1);
        at_last  = s_q.busy && (s_q.cnt == last_idx);
        in_ready = !s_q.busy || at_last;

        s_d = s_q;
        if (in_valid && in_ready) begin
            s_d.busy = 1'b1;
            s_d.mode = fmt_mode_e'(in_mode);
            s_d.cnt  = '0;
            s_d.pay  = in_data;
        end else if (at_last) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt  = s_q.cnt + 1'b1;
        end

        idx_a_d = quad_q ? {s_q.cnt[CNT_W-2:0], 1'b0} : s_q.cnt;
        idx_b_d = {s_q.cnt[CNT_W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    fmt_beat_slice #(
        .LANES(LANES), .BYTE_W(BYTE_W), .BIN_BEATS(BIN_BEATS)
    ) u_slice_a (
        .pay  (s_q.pay),
        .idx  (idx_a_d),
        .bits (bits_a),
        .flag (flag_a)
    );

    fmt_beat_slice #(
        .LANES(LANES), .BYTE_W(BYTE_W), .BIN_BEATS(BIN_BEATS)
    ) u_slice_b (
        .pay  (s_q.pay),
        .idx  (idx_b_d),
        .bits (bits_b),
        .flag (flag_b)
    );

    // symbol packing
    always_comb begin
        out_valid = s_q.busy;
        out_sym   = '0;
        out_dbi   = '0;
        if (s_q.busy) begin
            for (int l = 0; l < LANES; l++) begin
                out_sym[2*l +: 2] = quad_q ? {bits_a[l], bits_b[l]}
                                           : {1'b0, bits_a[l]};
            end
            for (int b = 0; b < NBYTES; b++) begin
                out_dbi[2*b +: 2] = quad_q ? {flag_a[b], flag_b[b]}
                                           : {1'b0, flag_a[b]};
            end
        end
    end
endmodule

// File: rtl/fmt_burst_dbi_chk.sv
module fmt_burst_dbi_chk #(
    parameter int LANES     = 16,
    parameter int BYTE_W    = 8,
    parameter int BIN_BEATS = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        in_valid,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic [2*LANES-1:0]          out_sym,
    input logic [2*(LANES/BYTE_W)-1:0] out_dbi,
    input logic                        quad_q
);
    localparam int NBYTES    = LANES / BYTE_W;
    localparam int SYM_BEATS = BIN_BEATS / 2;
    localparam int CNT_W     = $clog2(BIN_BEATS);

    logic [CNT_W-1:0] bc;
    logic [CNT_W-1:0] lastc;
    logic [LANES-1:0] v_lo, v_hi;
    logic [NBYTES-1:0] f_hi;

    always_comb begin
        lastc = quad_q ? CNT_W'(SYM_BEATS - 1) : CNT_W'(BIN_BEATS - 1);
        for (int l = 0; l < LANES; l++) begin
            v_lo[l] = out_sym[2*l];
            v_hi[l] = out_sym[2*l+1];
        end
        for (int b = 0; b < NBYTES; b++) begin
            f_hi[b] = out_dbi[2*b+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc <= '0;
        end else if (in_valid && in_ready) begin
            bc <= '0;
        end else if (out_valid) begin
            bc <= bc + 1'b1;
        end
    end

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);                                  // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (in_ready && out_sym == '0 && out_dbi == '0));           // R9

    AST_READY_LOW_MIDBURST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bc != lastc) |-> !in_ready);                              // R6

    AST_READY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bc == lastc) |-> in_ready);                               // R7

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_ready) |=> $stable(quad_q));                          // R8

    AST_BIN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !quad_q) |-> (v_hi == '0 && f_hi == '0));                 // R2

    for (genvar b = 0; b < NBYTES; b++) begin : g_weight
        AST_BYTE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($countones(v_lo[b*BYTE_W +: BYTE_W]) <= BYTE_W/2 &&
                           $countones(v_hi[b*BYTE_W +: BYTE_W]) <= BYTE_W/2));  // R4
    end
endmodule

bind fmt_burst_dbi fmt_burst_dbi_chk #(
    .LANES(LANES), .BYTE_W(BYTE_W), .BIN_BEATS(BIN_BEATS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .out_dbi   (out_dbi),
    .quad_q    (quad_q)
);

// File: tb/tb_fmt_burst_dbi.sv
`timescale 1ns/1ps
module tb_fmt_burst_dbi;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_data = '0;
    logic         in_mode = 1'b0;
    logic         out_valid;
    logic [31:0]  out_sym;
    logic [3:0]   out_dbi;

    int ntot = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fmt_burst_dbi dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mode(in_mode), .out_valid(out_valid),
        .out_sym(out_sym), .out_dbi(out_dbi)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        ntot++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one binary beat after per-byte inversion (R4)
    function automatic logic [15:0] bin_beat(input logic [255:0] d, input int j,
                                             output logic [1:0] fl);
        logic [15:0] r;
        r = d[16*j +: 16];
        for (int b = 0; b < 2; b++) begin
            int c = 0;
            for (int i = 0; i < 8; i++) c += int'(r[8*b+i]);
            fl[b] = (c > 4);
            if (c > 4) r[8*b +: 8] = ~r[8*b +: 8];
        end
        return r;
    endfunction

    task automatic expect_burst(input logic [255:0] d, input logic m, input bit chain,
                                input logic [255:0] nd, input logic nm);
        int n;
        n = m ? 8 : 16;
        for (int k = 0; k < n; k++) begin
            logic [15:0] ba, bb;
            logic [1:0]  fa, fb;
            logic [31:0] es;
            logic [3:0]  ed;
            @(negedge clk);
            es = '0;
            ed = '0;
            if (!m) begin
                ba = bin_beat(d, k, fa);
                for (int l = 0; l < 16; l++) es[2*l] = ba[l];
                for (int b = 0; b < 2; b++) ed[2*b] = fa[b];
            end else begin
                ba = bin_beat(d, 2*k, fa);
                bb = bin_beat(d, 2*k+1, fb);
                for (int l = 0; l < 16; l++) es[2*l +: 2] = {ba[l], bb[l]};
                for (int b = 0; b < 2; b++) ed[2*b +: 2] = {fa[b], fb[b]};
            end
            check(64'(out_valid), 64'(1), "R1 out_valid in burst");
            check(64'(out_sym), 64'(es), m ? "R3 R4 R8 four-level symbols" : "R2 R4 R8 binary symbols");
            check(64'(out_dbi), 64'(ed), "R5 inversion flags");
            check(64'(in_ready), 64'(k == n-1), "R6 ready during burst");
            if (k < n-1) begin
                in_valid = 1'b1; in_data = ~d; in_mode = ~m;   // R8: ignored mid-burst
            end else if (chain) begin
                in_valid = 1'b1; in_data = nd; in_mode = nm;   // R7
            end else begin
                in_valid = 1'b0;
            end
        end
        if (!chain) begin
            @(negedge clk);
            check(64'(out_valid), 64'(0), "R9 idle after burst");
            check(64'(in_ready), 64'(1), "R9 ready when idle");
            check(64'(out_sym), 64'(0), "R9 quiet symbols");
        end
    endtask

    task automatic send(input logic [255:0] d, input logic m);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_mode = m;
        expect_burst(d, m, 1'b0, '0, 1'b0);
    endtask

    initial begin
        logic [255:0] d;
        logic [31:0]  lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(64'(out_valid), 64'(0), "R9 reset valid");
        check(64'(in_ready), 64'(1), "R9 reset ready");
        check(64'(out_dbi), 64'(0), "R9 reset flags");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(64'(out_valid), 64'(0), "R9 idle without offer");

        // R4 extremes
        send('0, 1'b0);
        send('1, 1'b0);
        send('0, 1'b1);
        send('1, 1'b1);

        // every byte value in both modes (R4 thresholds at four and five ones)
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 32; i++) d[8*i +: 8] = 8'(p*32 + i);
            send(d, 1'b0);
            send(d, 1'b1);
        end

        // back-to-back chain with mode changes (R7)
        lf = 32'h1234_5678;
        begin
            logic [255:0] d1, d2, d3;
            for (int i = 0; i < 8; i++) begin
                lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                d1[32*i +: 32] = lf;
                d2[32*i +: 32] = ~lf ^ 32'h0F0F_1F1F;
                d3[32*i +: 32] = lf + 32'h3C3C_0F0F;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = d1; in_mode = 1'b0;
            expect_burst(d1, 1'b0, 1'b1, d2, 1'b1);
            expect_burst(d2, 1'b1, 1'b1, d3, 1'b0);
            expect_burst(d3, 1'b0, 1'b1, d1, 1'b1);
            expect_burst(d1, 1'b1, 1'b0, '0, 1'b0);
        end

        // pseudo-random payloads
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 8; i++) begin
                lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                d[32*i +: 32] = lf;
            end
            send(d, t[0]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            ntot++;
            nfail++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", ntot - nfail, ntot);
            $finish;
        end
    end
endmodule